// File: doc/BRIEF.md
# DMA Channel Request-Pending Tracker

This block keeps the pending state for each channel of a small multi-channel DMA controller and decides which channel owns the transfer engine. Peripherals raise single-cycle hardware request pulses, and software raises single-cycle request strobes. Either kind marks the channel pending at once, even while the channel or the whole controller is switched off. The request is held until the channel becomes eligible, and then until its transfer finishes.

Eligible channels are those that are pending, have their channel enable set, and are covered by the global enable. A fixed-priority arbiter grants one of them, and the grant is held until the channel's frame or block completes. Working frame and element counts are loaded from the channel's initial values on the first grant and advance through an element-done handshake. They are reloaded when a block completes, when an error occurs, or when auto-initiation repeats a block. Completion clears the pending bit, except when a block ends on a software-requested auto-initiated channel. In that case the bit stays set and the block runs again.

Top module: `dma_pend_tracker`

## Requirements
- R1: A pulse on `hw_req[i]` or `sw_req[i]` makes `pend[i]` 1 after the next clock edge, whatever the values of `ch_en`, `dma_en` and `auto_init`. If a request and a clearing event reach the same channel in the same cycle, the request wins.
- R2: While no grant is active, a pending channel is granted only when its `ch_en` bit and `dma_en` are both 1. A request that arrives while the channel is disabled stays pending. `grant_vld` goes to 1 one edge after the channel becomes eligible.
- R3: When several channels are eligible while no grant is active, the lowest-numbered one wins. `grant_ch` gives the winner as a binary channel index.
- R4: A grant is never pre-empted. It lasts until the granted channel finishes its frame (frame mode) or its block (block mode), or until an error ends it. `grant_vld` returns to 0 at that same edge.
- R5: On a channel's first grant, its working counts are loaded from `init_fcnt` and `init_ecnt`. Each `elem_done` during a grant lowers the element count by one. On the last element of a frame, the element count reloads and the frame count drops by one. Channel i's counts are at `cur_fcnt[i*FW +: FW]` and `cur_ecnt[i*EW +: EW]`.
- R6: In frame mode (`blk_mode[i]`=0), pending clears at every frame end. Each frame needs its own request, and the frame count carries over between frames.
- R7: In block mode (`blk_mode[i]`=1), pending clears at block end. When any block completes, both working counts return to their initial values.
- R8: With `auto_init[i]`=1 and the last request from hardware, pending clears at block end. No new grant occurs until another request arrives.
- R9: With `auto_init[i]`=1 and the last request from software, pending stays 1 at block end. The grant drops for one cycle, and the channel is then granted again with reloaded counts.
- R10: `err` during a grant clears the granted channel's pending bit, ends the grant, and restores that channel's working counts to their initial values.
- R11: A request that arrives while the channel is already pending merges into the existing pending bit. One completion unit then clears it.
- R12: `elem_done` and `err` have no effect on pending bits or counts while no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | Global enable for arbitration |
| ch_en | input | NCH | Per-channel enable |
| hw_req | input | NCH | Hardware request pulses |
| sw_req | input | NCH | Software request strobes |
| blk_mode | input | NCH | 1 = block completion unit, 0 = frame |
| auto_init | input | NCH | Auto-initiation select |
| init_fcnt | input | NCH*FW | Initial frame counts, channel i at [i*FW +: FW] |
| init_ecnt | input | NCH*EW | Initial element counts, channel i at [i*EW +: EW] |
| elem_done | input | 1 | One element of the granted channel finished |
| err | input | 1 | Error during the granted transfer |
| pend | output | NCH | Pending bits |
| grant_vld | output | 1 | A channel holds the grant |
| grant_ch | output | CHW | Index of the granted channel |
| cur_fcnt | output | NCH*FW | Working frame counts |
| cur_ecnt | output | NCH*EW | Working element counts |

## Verification
The properties assume that the initial frame and element counts of any channel that is granted are nonzero and stay fixed while that channel holds working counts. They also assume that `elem_done` and `err` are meaningful only during a grant. The stimulus sets every channel's configuration once, before its first request, and changes only the auto-initiation bit between grants or on the final block. It pulses `elem_done` and `err` outside a grant only in the scenario that checks they are ignored.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
    typedef enum logic {
        XK_FRAME = 1'b0,
        XK_BLOCK = 1'b1
    } xfer_kind_e;
endpackage

// File: rtl/dpt_prio_arb.sv
module dpt_prio_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          vld,
    output logic [IW-1:0] idx
);
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dpt_chan.sv
module dpt_chan
    import dpt_pkg::*;
#(
    parameter int FW = 8,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_req,
    input  logic          sw_req,
    input  logic          blk_mode,
    input  logic          aim_on,
    input  logic [FW-1:0] init_f,
    input  logic [EW-1:0] init_e,
    input  logic          start,
    input  logic          step,
    input  logic          abort,
    output logic          pend,
    output logic [FW-1:0] fcnt,
    output logic [EW-1:0] ecnt,
    output logic          xfer_end
);
    typedef struct packed {
        logic          pend;
        logic          sw_src;
        logic          loaded;
        logic [FW-1:0] fcnt;
        logic [EW-1:0] ecnt;
    } ch_st_t;

    ch_st_t     st_q, st_d;
    xfer_kind_e kind;
    logic       frm_end, blk_end, keep, clr;

    assign kind = xfer_kind_e'(blk_mode);

    always_comb begin
        st_d     = st_q;
        frm_end  = step && (st_q.ecnt <= EW'(1));
        blk_end  = frm_end && (st_q.fcnt <= FW'(1));
        keep     = blk_end && aim_on && st_q.sw_src && !abort;
        xfer_end = abort || ((kind == XK_BLOCK) ? blk_end : frm_end);
        clr      = xfer_end && !keep;

        if (start && !st_q.loaded) begin
            st_d.fcnt   = init_f;
            st_d.ecnt   = init_e;
            st_d.loaded = 1'b1;
        end
        if (step) begin
            if (frm_end) begin
                st_d.ecnt = init_e;
                if (blk_end) begin
                    st_d.fcnt   = init_f;
                    st_d.loaded = 1'b0;
                end else begin
                    st_d.fcnt = st_q.fcnt - FW'(1);
                end
            end else begin
                st_d.ecnt = st_q.ecnt - EW'(1);
            end
        end
        if (abort) begin
            st_d.fcnt   = init_f;
            st_d.ecnt   = init_e;
            st_d.loaded = 1'b0;
        end

        st_d.pend = (st_q.pend && !clr) || hw_req || sw_req;
        if (sw_req) begin
            st_d.sw_src = 1'b1;
        end else if (hw_req) begin
            st_d.sw_src = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign fcnt = st_q.fcnt;
    assign ecnt = st_q.ecnt;

    a_r1_req_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req || sw_req) |=> pend);
    a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !hw_req && !sw_req) |=> !pend);
    a_r5_loaded_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.loaded |-> (fcnt != '0 && ecnt != '0));
    a_r7_block_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && !abort) |=> (fcnt == $past(init_f) && ecnt == $past(init_e)));
endmodule

// File: rtl/dma_pend_tracker.sv
module dma_pend_tracker
    import dpt_pkg::*;
#(
    parameter int NCH = 4,
    parameter int FW  = 8,
    parameter int EW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    hw_req,
    input  logic [NCH-1:0]    sw_req,
    input  logic [NCH-1:0]    blk_mode,
    input  logic [NCH-1:0]    auto_init,
    input  logic [NCH*FW-1:0] init_fcnt,
    input  logic [NCH*EW-1:0] init_ecnt,
    input  logic              elem_done,
    input  logic              err,
    output logic [NCH-1:0]    pend,
    output logic              grant_vld,
    output logic [CHW-1:0]    grant_ch,
    output logic [NCH*FW-1:0] cur_fcnt,
    output logic [NCH*EW-1:0] cur_ecnt
);
    typedef struct packed {
        logic           busy;
        logic [CHW-1:0] gch;
    } gr_st_t;

    gr_st_t         st_q, st_d;
    logic [NCH-1:0] eligible, start_v, step_v, abort_v, end_v;
    logic           arb_vld;
    logic [CHW-1:0] arb_idx;

    assign eligible = pend & ch_en & {NCH{dma_en}};

    dpt_prio_arb #(.N(NCH), .IW(CHW)) arb_i (
        .req (eligible),
        .vld (arb_vld),
        .idx (arb_idx)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dpt_chan #(.FW(FW), .EW(EW)) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .hw_req   (hw_req[c]),
            .sw_req   (sw_req[c]),
            .blk_mode (blk_mode[c]),
            .aim_on   (auto_init[c]),
            .init_f   (init_fcnt[c*FW +: FW]),
            .init_e   (init_ecnt[c*EW +: EW]),
            .start    (start_v[c]),
            .step     (step_v[c]),
            .abort    (abort_v[c]),
            .pend     (pend[c]),
            .fcnt     (cur_fcnt[c*FW +: FW]),
            .ecnt     (cur_ecnt[c*EW +: EW]),
            .xfer_end (end_v[c])
        );
    end

    always_comb begin
        start_v = '0;
        step_v  = '0;
        abort_v = '0;
        if (st_q.busy) begin
            step_v[st_q.gch]  = elem_done;
            abort_v[st_q.gch] = err;
        end else if (arb_vld) begin
            start_v[arb_idx] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (end_v[st_q.gch]) begin
                st_d.busy = 1'b0;
            end
        end else if (arb_vld) begin
            st_d.busy = 1'b1;
            st_d.gch  = arb_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_vld = st_q.busy;
    assign grant_ch  = st_q.gch;

    a_r2_grant_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && arb_vld) |-> (dma_en && ch_en[arb_idx] && pend[arb_idx]));
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        arb_vld |-> ((eligible & ((NCH'(1) << arb_idx) - NCH'(1))) == '0));
    a_r3_grant_follows_arb: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && arb_vld) |=> (grant_vld && grant_ch == $past(arb_idx)));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !elem_done && !err) |=> (grant_vld && $stable(grant_ch)));
    a_r4_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> pend[st_q.gch]);
    a_r12_idle_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !arb_vld) |=> ($stable(cur_fcnt) && $stable(cur_ecnt)));
endmodule

// File: tb/dma_pend_tracker_tb.sv
module dma_pend_tracker_tb_top;
    localparam int NCH = 4;
    localparam int FW  = 8;
    localparam int EW  = 8;
    localparam int CHW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dma_en = 1'b0;
    logic [NCH-1:0]    ch_en = '0, hw_req = '0, sw_req = '0;
    logic [NCH-1:0]    blk_mode, auto_init;
    logic [NCH*FW-1:0] init_fcnt;
    logic [NCH*EW-1:0] init_ecnt;
    logic              elem_done = 1'b0, err = 1'b0;
    logic [NCH-1:0]    pend;
    logic              grant_vld;
    logic [CHW-1:0]    grant_ch;
    logic [NCH*FW-1:0] cur_fcnt;
    logic [NCH*EW-1:0] cur_ecnt;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_pend_tracker #(.NCH(NCH), .FW(FW), .EW(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .ch_en(ch_en),
        .hw_req(hw_req), .sw_req(sw_req), .blk_mode(blk_mode),
        .auto_init(auto_init), .init_fcnt(init_fcnt), .init_ecnt(init_ecnt),
        .elem_done(elem_done), .err(err), .pend(pend), .grant_vld(grant_vld),
        .grant_ch(grant_ch), .cur_fcnt(cur_fcnt), .cur_ecnt(cur_ecnt)
    );

    function automatic int fc(int ch);
        return int'(cur_fcnt[ch*FW +: FW]);
    endfunction
    function automatic int ec(int ch);
        return int'(cur_ecnt[ch*EW +: EW]);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask
    task automatic pulse_hw(int ch);
        hw_req[ch] = 1'b1; tick(); hw_req[ch] = 1'b0;
    endtask
    task automatic pulse_sw(int ch);
        sw_req[ch] = 1'b1; tick(); sw_req[ch] = 1'b0;
    endtask
    task automatic elems(int n);
        for (int k = 0; k < n; k++) begin
            elem_done = 1'b1; tick();
        end
        elem_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset pend", int'(pend), 0);
        chk("R2 reset grant", int'(grant_vld), 0);
        chk("R5 reset fcnt", int'(cur_fcnt), 0);
    endtask

    task automatic t_disabled_buffer();
        pulse_hw(1);
        chk("R1 hw pend while disabled", int'(pend[1]), 1);
        tick(); tick(); tick();
        chk("R2 no grant while disabled", int'(grant_vld), 0);
        pulse_sw(2);
        chk("R1 sw pend with dma_en 0", int'(pend[2]), 1);
        dma_en = 1'b1; ch_en = '1;
        tick();
        chk("R2 grant after enable", int'(grant_vld), 1);
        chk("R3 lowest wins", int'(grant_ch), 1);
        chk("R5 frame count loaded", fc(1), 2);
        elems(1);
        chk("R5 element count drops", ec(1), 1);
        elems(1);
        chk("R5 frame count drops", fc(1), 1);
        chk("R5 element count reloads", ec(1), 2);
        chk("R4 grant held over frame", int'(grant_vld), 1);
        elems(2);
        chk("R7 block end clears pend", int'(pend[1]), 0);
        chk("R4 grant ends at block", int'(grant_vld), 0);
        chk("R7 frame count reloaded", fc(1), 2);
        tick();
        chk("R3 next channel granted", int'(grant_ch), 2);
        elems(1);
        chk("R7 sw block clears pend", int'(pend[2]), 0);
    endtask

    task automatic t_frame_type();
        pulse_hw(0); tick();
        chk("R6 frame grant", int'(grant_vld), 1);
        elems(2);
        chk("R6 frame end clears pend", int'(pend[0]), 0);
        chk("R6 grant ends at frame", int'(grant_vld), 0);
        chk("R6 frame count carried", fc(0), 2);
        tick(); tick();
        chk("R6 next frame waits for request", int'(grant_vld), 0);
        pulse_hw(0); tick(); elems(2);
        chk("R6 second frame", fc(0), 1);
        pulse_hw(0); tick(); elems(2);
        chk("R7 block reload after last frame", fc(0), 3);
        chk("R6 pend clear after last frame", int'(pend[0]), 0);
    endtask

    task automatic t_aim_hw();
        pulse_hw(3); tick();
        chk("R8 granted", int'(grant_ch), 3);
        elems(2);
        chk("R8 hw auto-init clears pend", int'(pend[3]), 0);
        tick(); tick();
        chk("R8 no regrant without request", int'(grant_vld), 0);
    endtask

    task automatic t_aim_sw();
        pulse_sw(3); tick();
        chk("R9 granted", int'(grant_vld), 1);
        elems(2);
        chk("R9 sw auto-init keeps pend", int'(pend[3]), 1);
        chk("R9 grant drops at block end", int'(grant_vld), 0);
        tick();
        chk("R9 regranted", int'(grant_vld), 1);
        chk("R9 regranted channel", int'(grant_ch), 3);
        chk("R9 counts reloaded", ec(3), 2);
        auto_init[3] = 1'b0;
        elems(2);
        chk("R9 stops when auto-init off", int'(pend[3]), 0);
    endtask

    task automatic t_error();
        pulse_hw(1); tick(); elems(1);
        chk("R10 mid-block element count", ec(1), 1);
        err = 1'b1; tick(); err = 1'b0;
        chk("R10 error clears pend", int'(pend[1]), 0);
        chk("R10 error ends grant", int'(grant_vld), 0);
        chk("R10 frame count restored", fc(1), 2);
        chk("R10 element count restored", ec(1), 2);
    endtask

    task automatic t_merge();
        ch_en[0] = 1'b0;
        pulse_hw(0); pulse_hw(0);
        chk("R11 pend after two requests", int'(pend[0]), 1);
        ch_en[0] = 1'b1; tick();
        chk("R11 granted", int'(grant_ch), 0);
        elems(2);
        chk("R11 one frame clears merged pend", int'(pend[0]), 0);
        tick(); tick();
        chk("R11 no second grant", int'(grant_vld), 0);
    endtask

    task automatic t_idle_ignore();
        ch_en[2] = 1'b0;
        pulse_hw(2);
        elem_done = 1'b1; err = 1'b1; tick(); elem_done = 1'b0; err = 1'b0;
        chk("R12 pend kept when idle", int'(pend[2]), 1);
        chk("R12 frame count unchanged", fc(2), 1);
        chk("R12 element count unchanged", ec(2), 1);
        ch_en[2] = 1'b1; tick(); elems(1);
        chk("R12 later transfer completes", int'(pend[2]), 0);
    endtask

    task automatic t_no_preempt();
        dma_en = 1'b0;
        pulse_hw(1); pulse_hw(2);
        dma_en = 1'b1; tick();
        chk("R3 lowest of two", int'(grant_ch), 1);
        pulse_hw(0);
        chk("R4 no preemption", int'(grant_ch), 1);
        elems(4);
        chk("R4 grant ends", int'(grant_vld), 0);
        tick();
        chk("R3 ch0 beats ch2", int'(grant_ch), 0);
        elems(2); tick();
        chk("R3 ch2 last", int'(grant_ch), 2);
        elems(1);
        chk("R7 all clear", int'(pend), 0);
    endtask

    initial begin
        blk_mode  = 4'b1110;
        auto_init = 4'b1000;
        init_fcnt = {8'd1, 8'd1, 8'd2, 8'd3};
        init_ecnt = {8'd2, 8'd1, 8'd2, 8'd2};
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_disabled_buffer();
        t_frame_type();
        t_aim_hw();
        t_aim_sw();
        t_error();
        t_merge();
        t_idle_ignore();
        t_no_preempt();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule